// File: doc/BRIEF.md
# Disk-Change Flag Register

This block keeps one sticky disk-change flag for each drive on a removable-media controller and returns the flag of the selected drive through a byte-wide read port. The flag reports that the medium may have been swapped since the host last moved the head. It is set at reset, whenever a medium is inserted or ejected, and for as long as a drive holds no medium. It is cleared only when the seek logic moves that drive's head to a different cylinder while a medium is present.

The seek engine reports every step request as a one-cycle strobe that carries the drive number, the cylinder the head is on and the target cylinder. The block treats the request as a real head movement only when the two cylinders differ. The host reads the change register at address offset 7. The flag sits in bit 7, the other bits read zero, and reading has no side effect on any flag.

Top module: `disk_change_reg`

## Requirements
- R1: After synchronous reset every drive's flag is set, `rd_data` is 0x00, and the first read of offset 7 returns 0x80 for every drive.
- R2: A read at any offset, repeated any number of times, never changes any flag.
- R3: An insert event for a drive sets that drive's flag, or leaves it set, on the next clock edge.
- R4: A step strobe whose present cylinder equals its target cylinder changes no flag.
- R5: A step strobe whose cylinders differ clears the flag of the addressed drive on the next edge, provided that drive has media present and no insert or eject event in the same cycle. Other drives' flags are not affected.
- R6: An eject event sets the drive's flag, and while `media_present` for that drive is low the flag stays set, even across steps to a different cylinder.
- R7: A read of offset 7 returns {flag, 7'b0000000}, with the flag in bit 7. A read of any other offset returns 0x00.
- R8: When an insert event and a moving step for the same drive fall in the same cycle, the flag is set after that edge.
- R9: `rd_data` takes the read value on the clock edge after a cycle with `rd_en` high, and holds its value in every cycle with `rd_en` low.
- R10: A read returns the flag of the drive given by `rd_drive` in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| media_present | input | NUM_DRIVES | Level per drive: a medium is in the drive |
| media_insert | input | NUM_DRIVES | One-cycle pulse per drive: a medium was inserted |
| media_eject | input | NUM_DRIVES | One-cycle pulse per drive: a medium was removed |
| step_valid | input | 1 | One-cycle strobe from the seek logic |
| step_drive | input | DRV_W | Drive addressed by the step strobe |
| step_cur_cyl | input | CYL_W | Cylinder the head is on before the step |
| step_tgt_cyl | input | CYL_W | Cylinder the step moves to |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register offset within the controller |
| rd_drive | input | DRV_W | Drive whose flag a read reports |
| rd_data | output | 8 | Registered read value |

## Verification
A medium insertion and a head step that moves to a new cylinder both act on the same drive's flag. They can arrive in the same clock cycle, where one would set the flag and the other clear it. The bench drives both in one cycle on purpose, both right after a fresh insert and inside the random phase, where insert pulses and moving steps are drawn independently for the same drive. It judges the result by a later read that must still show 0x80, because the set must win. A following step on its own then has to clear the flag, which shows the earlier clear was suppressed and not simply lost.

// File: rtl/chg_pkg.sv
package chg_pkg;

    // Bit of the change register that holds the flag
    localparam int FLAG_BIT = 7;

    // Per-drive request into the flag latch for one cycle
    typedef struct packed {
        logic set;   // insert, eject or no medium
        logic clr;   // qualified head movement
    } flag_req_t;

    // What a read returns
    typedef enum logic [0:0] {
        RSRC_ZERO   = 1'b0,
        RSRC_CHANGE = 1'b1
    } rd_src_t;

    // Place the flag into the register byte
    function automatic logic [7:0] pack_change(input logic chg);
        logic [7:0] b;
        b = 8'h00;
        b[FLAG_BIT] = chg;
        return b;
    endfunction

endpackage

// File: rtl/chg_step_qual.sv
module chg_step_qual
    import chg_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic [NUM_DRIVES-1:0]  media_present,
    input  logic [NUM_DRIVES-1:0]  media_insert,
    input  logic [NUM_DRIVES-1:0]  media_eject,
    input  logic                   step_valid,
    input  logic [DRV_W-1:0]       step_drive,
    input  logic [CYL_W-1:0]       step_cur_cyl,
    input  logic [CYL_W-1:0]       step_tgt_cyl,
    output flag_req_t [NUM_DRIVES-1:0] req
);

    // A strobe is a real step only when the head changes cylinder
    logic moved;
    assign moved = step_valid && (step_cur_cyl != step_tgt_cyl);

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        logic hit;
        assign hit       = moved && (step_drive == DRV_W'(d));
        assign req[d].set = media_insert[d] | media_eject[d] | ~media_present[d];
        assign req[d].clr = hit & media_present[d];
    end

endmodule

// File: rtl/chg_latch_bank.sv
module chg_latch_bank
    import chg_pkg::*;
#(
    parameter int NUM_DRIVES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  flag_req_t [NUM_DRIVES-1:0] req,
    output logic [NUM_DRIVES-1:0]      flags
);

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b1;
            end else if (req[d].set) begin
                flag_q <= 1'b1;        // set wins over a same-cycle clear
            end else if (req[d].clr) begin
                flag_q <= 1'b0;
            end
        end
        assign flags[d] = flag_q;
    end

endmodule

// File: rtl/chg_read_port.sv
module chg_read_port
    import chg_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int ADDR_W     = 3,
    parameter int CHG_OFFSET = 7,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DRV_W-1:0]      rd_drive,
    input  logic [NUM_DRIVES-1:0] flags,
    output logic [7:0]            rd_data
);

    rd_src_t    src;
    logic       sel_flag;
    logic [7:0] rd_next;
    logic [7:0] rd_q;

    assign src      = (rd_addr == ADDR_W'(CHG_OFFSET)) ? RSRC_CHANGE : RSRC_ZERO;
    assign sel_flag = flags[rd_drive];

    always_comb begin
        unique case (src)
            RSRC_CHANGE: rd_next = pack_change(sel_flag);
            default:     rd_next = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 8'h00;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/disk_change_reg.sv
module disk_change_reg
    import chg_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    parameter int ADDR_W     = 3,
    parameter int CHG_OFFSET = 7,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_DRIVES-1:0] media_present,
    input  logic [NUM_DRIVES-1:0] media_insert,
    input  logic [NUM_DRIVES-1:0] media_eject,
    input  logic                  step_valid,
    input  logic [DRV_W-1:0]      step_drive,
    input  logic [CYL_W-1:0]      step_cur_cyl,
    input  logic [CYL_W-1:0]      step_tgt_cyl,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DRV_W-1:0]      rd_drive,
    output logic [7:0]            rd_data
);

    flag_req_t [NUM_DRIVES-1:0] req;
    logic [NUM_DRIVES-1:0]      chg_flags;

    chg_step_qual #(
        .NUM_DRIVES (NUM_DRIVES),
        .CYL_W      (CYL_W)
    ) u_qual (
        .media_present (media_present),
        .media_insert  (media_insert),
        .media_eject   (media_eject),
        .step_valid    (step_valid),
        .step_drive    (step_drive),
        .step_cur_cyl  (step_cur_cyl),
        .step_tgt_cyl  (step_tgt_cyl),
        .req           (req)
    );

    chg_latch_bank #(
        .NUM_DRIVES (NUM_DRIVES)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .flags (chg_flags)
    );

    chg_read_port #(
        .NUM_DRIVES (NUM_DRIVES),
        .ADDR_W     (ADDR_W),
        .CHG_OFFSET (CHG_OFFSET)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_drive (rd_drive),
        .flags    (chg_flags),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/chg_checker.sv
module chg_checker #(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_DRIVES-1:0] media_present,
    input logic [NUM_DRIVES-1:0] media_insert,
    input logic [NUM_DRIVES-1:0] media_eject,
    input logic                  step_valid,
    input logic [DRV_W-1:0]      step_drive,
    input logic [CYL_W-1:0]      step_cur_cyl,
    input logic [CYL_W-1:0]      step_tgt_cyl,
    input logic                  rd_en,
    input logic [NUM_DRIVES-1:0] chg_flags,
    input logic [7:0]            rd_data
);

    AST_RESET_ALL_SET: assert property (@(posedge clk)
        $past(rst) |-> (&chg_flags && rd_data == 8'h00)); // R1

    AST_NO_CLEAR_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> (($past(chg_flags) & ~chg_flags) == '0)); // R2

    AST_INSERT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|media_insert) |=> ((chg_flags & $past(media_insert)) == $past(media_insert))); // R3

    AST_SAME_CYL_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_cur_cyl == step_tgt_cyl)
        |=> (($past(chg_flags) & ~chg_flags) == '0)); // R4

    AST_MOVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_cur_cyl != step_tgt_cyl && media_present[step_drive]
         && !media_insert[step_drive] && !media_eject[step_drive])
        |=> !chg_flags[$past(step_drive)]); // R5

    AST_NO_MEDIA_SET: assert property (@(posedge clk) disable iff (rst)
        (|(media_eject | ~media_present))
        |=> ((chg_flags & $past(media_eject | ~media_present))
             == $past(media_eject | ~media_present))); // R6

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:0] == 7'b0); // R7

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R9

endmodule

bind disk_change_reg chg_checker #(
    .NUM_DRIVES (NUM_DRIVES),
    .CYL_W      (CYL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .media_present (media_present),
    .media_insert  (media_insert),
    .media_eject   (media_eject),
    .step_valid    (step_valid),
    .step_drive    (step_drive),
    .step_cur_cyl  (step_cur_cyl),
    .step_tgt_cyl  (step_tgt_cyl),
    .rd_en         (rd_en),
    .chg_flags     (chg_flags),
    .rd_data       (rd_data)
);

// File: tb/sim_disk_change_reg.sv
`timescale 1ns/1ps
module sim_disk_change_reg;

    localparam int N  = 4;
    localparam int CW = 8;
    localparam int DW = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  media_present, media_insert, media_eject;
    logic          step_valid;
    logic [DW-1:0] step_drive;
    logic [CW-1:0] step_cur_cyl, step_tgt_cyl;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_drive;
    logic [7:0]    rd_data;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [N-1:0] m_flag;   // bench model of flags
    logic [7:0]   m_rd;     // bench model of rd_data

    always #2.5 clk = ~clk;

    disk_change_reg #(.NUM_DRIVES(N), .CYL_W(CW), .ADDR_W(AW), .CHG_OFFSET(7)) u0 (
        .clk(clk), .rst(rst), .media_present(media_present),
        .media_insert(media_insert), .media_eject(media_eject),
        .step_valid(step_valid), .step_drive(step_drive),
        .step_cur_cyl(step_cur_cyl), .step_tgt_cyl(step_tgt_cyl),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_drive(rd_drive), .rd_data(rd_data)
    );

    function automatic logic [N-1:0] next_flags(
        input logic [N-1:0] f, input logic [N-1:0] pres, ins, ej,
        input logic sv, input logic [DW-1:0] sd, input logic [CW-1:0] oc, nc);
        logic [N-1:0] r;
        r = f;
        for (int d = 0; d < N; d++) begin
            if (ins[d] || ej[d] || !pres[d]) r[d] = 1'b1;
            else if (sv && sd == DW'(d) && oc != nc) r[d] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] read_val(input logic [N-1:0] f,
        input logic [AW-1:0] a, input logic [DW-1:0] dsel);
        return (a == AW'(7)) ? {f[dsel], 7'b0} : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // One cycle; called at a falling edge, returns at the next falling edge
    task automatic cycle(input logic [N-1:0] ins, ej, input logic sv,
        input logic [DW-1:0] sd, input logic [CW-1:0] oc, nc,
        input logic re, input logic [AW-1:0] ra, input logic [DW-1:0] rdv);
        logic [N-1:0] pres;
        pres = (media_present | ins) & ~ej;
        media_present = pres; media_insert = ins; media_eject = ej;
        step_valid = sv; step_drive = sd; step_cur_cyl = oc; step_tgt_cyl = nc;
        rd_en = re; rd_addr = ra; rd_drive = rdv;
        if (re) m_rd = read_val(m_flag, ra, rdv);
        m_flag = next_flags(m_flag, pres, ins, ej, sv, sd, oc, nc);
        @(negedge clk);
        media_insert = '0; media_eject = '0; step_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic step(input logic [DW-1:0] d, input logic [CW-1:0] oc, nc);
        cycle('0, '0, 1'b1, d, oc, nc, 1'b0, '0, '0);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cycle('0, '0, 1'b0, '0, '0, '0, 1'b1, a, d);
        check(req, rd_data, m_rd);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; media_present = '0; media_insert = '0; media_eject = '0;
        step_valid = 1'b0; step_drive = '0; step_cur_cyl = '0; step_tgt_cyl = '0;
        rd_en = 1'b0; rd_addr = '0; rd_drive = '0;
        m_flag = '1; m_rd = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rd_data after reset", rd_data, 8'h00);
        for (int d = 0; d < N; d++) rd_chk("R1 flag set after reset", 3'd7, DW'(d));

        // R2: repeated reads keep the flag
        rd_chk("R2 repeat read", 3'd7, 0);
        rd_chk("R2 repeat read", 3'd7, 0);
        // R6: moving step without media keeps flag
        step(0, 8'd0, 8'd1);
        rd_chk("R6 step without media", 3'd7, 0);
        // R3: insert keeps flag set
        cycle(4'b0001, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0);
        rd_chk("R3 after insert", 3'd7, 0);
        // R4: same-cylinder step is not a step
        step(0, 8'd0, 8'd0);
        rd_chk("R4 same cylinder", 3'd7, 0);
        // R9: hold while no read, then R5 clear
        step(0, 8'd0, 8'd1);
        check("R9 hold without rd_en", rd_data, 8'h80);
        rd_chk("R5 moving step clears", 3'd7, 0);
        rd_chk("R2 cleared stays cleared", 3'd7, 0);
        rd_chk("R10 other drive still set", 3'd7, 1);
        // R7: other offsets read zero
        rd_chk("R7 other offset", 3'd3, 1);
        rd_chk("R7 offset 0", 3'd0, 1);
        // R6: eject sets, steps leave set
        cycle('0, 4'b0001, 1'b0, '0, '0, '0, 1'b0, '0, '0);
        rd_chk("R6 after eject", 3'd7, 0);
        step(0, 8'd1, 8'd2);
        rd_chk("R6 step after eject", 3'd7, 0);
        // R8: insert with moving step in same cycle
        cycle(4'b0001, '0, 1'b1, 2'd0, 8'd2, 8'd3, 1'b0, '0, '0);
        rd_chk("R8 insert and step together", 3'd7, 0);
        step(0, 8'd3, 8'd4);
        rd_chk("R8 later step clears", 3'd7, 0);
        // R10: drive 2 cleared independently
        cycle(4'b0100, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0);
        step(2, 8'd5, 8'd9);
        rd_chk("R10 drive 2 cleared", 3'd7, 2);
        rd_chk("R10 drive 0 unchanged", 3'd7, 0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] ins, ej;
            logic sv, re;
            logic [DW-1:0] sd, rdv;
            logic [CW-1:0] oc, nc;
            logic [AW-1:0] ra;
            ins = ($urandom_range(0, 7) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
            ej  = ($urandom_range(0, 9) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
            ej  = ej & ~ins;
            sv  = $urandom_range(0, 1);
            sd  = DW'($urandom_range(0, N-1));
            oc  = CW'($urandom_range(0, 3));
            nc  = CW'($urandom_range(0, 3));
            re  = $urandom_range(0, 1);
            ra  = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, 7)) : 3'd7;
            rdv = DW'($urandom_range(0, N-1));
            cycle(ins, ej, sv, sd, oc, nc, re, ra, rdv);
            check(re ? "R7 R10 random read" : "R9 random hold", rd_data, m_rd);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule